// File: doc/BRIEF.md
# Master Veto and Sync Controller

This block sits on the master card of a trigger supervisor. It repeats each incoming trigger pulse to up to sixteen slave cards. It folds the busy lines returned by those slaves into a single veto that goes back to the trigger logic. The time this veto stays high is the total dead time of the acquisition chain. On a command strobe it sends a one-cycle sync-request pulse to every slave. A minimum number of triggers must pass between two accepted requests.

While it runs, the block divides time into windows of programmable length. In each window it counts three things: trigger rising edges, cycles with the veto high, and veto rising edges. At the end of each window the three counts go into one record of a small circular strip-chart memory, which can be read through an address port. A separate running counter tracks triggers that arrived while the veto was already raised.

Top module: `veto_sync_master`

## Requirements
- R1: While reset is held and right after it, `sync_out` is all zeros, `rec_stb` is 0, `log_ptr` is 0 and `vetoed_cnt` is 0.
- R2: `veto` is high in the same cycle exactly when some slot has both its `slv_busy` bit and its `slot_en` bit set. A busy line on a disabled slot has no effect on `veto`.
- R3: Every bit of `trig_out` equals `trig_in` in the same cycle.
- R4: An accepted `sync_cmd` sampled at a clock edge drives `sync_out` to all ones for exactly the cycle that follows that edge.
- R5: The first `sync_cmd` after reset is accepted. Once a request is accepted, later commands are ignored until at least `sync_gap` trigger rising edges have been seen. A trigger edge in the same cycle as an accepted command is not counted. A command sampled while `sync_out` is high is also ignored.
- R6: `vetoed_cnt` increases by one for each trigger rising edge sampled while `veto` is high. It does not change otherwise.
- R7: A window lasts `win_len` cycles, with 0 treated as 1. At the edge that closes a window, a record is written at the address `log_ptr` held before that edge. After that edge, `rec_stb` is high for one cycle and `log_ptr` has advanced by one, wrapping after 2^AW records.
- R8: Each record holds three counts over the window's cycles: trigger rising edges in bits [3*CW-1:2*CW], veto-high cycles in [2*CW-1:CW], and veto rising edges in [CW-1:0]. A rising edge is judged against the previous cycle, and the level before the first cycle after reset counts as 0.
- R9: `rd_data` shows the record stored at `rd_addr` in the same cycle. Once the memory wraps, the oldest record is overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 1 | Trigger from the trigger logic |
| trig_out | output | N_SLV | Trigger repeated to each slave |
| slv_busy | input | N_SLV | Combined busy line from each slave |
| slot_en | input | N_SLV | Per-slot enable for the veto OR |
| veto | output | 1 | Global veto to the trigger logic |
| sync_cmd | input | 1 | Sync-request command strobe |
| sync_gap | input | GAP_W | Trigger edges required between accepted requests |
| sync_out | output | N_SLV | Sync-request pulse to each slave |
| win_len | input | WIN_W | Measurement window length in cycles |
| rec_stb | output | 1 | Record-written strobe |
| log_ptr | output | AW | Next record address |
| rd_addr | input | AW | Record read address |
| rd_data | output | 3*CW | Record at `rd_addr` |
| vetoed_cnt | output | CW | Running count of triggers seen under veto |

## Verification
The properties assume that `trig_in`, `slv_busy` and `sync_cmd` are synchronous to `clk`. They also assume that `slot_en`, `sync_gap` and `win_len` change only between phases of operation. The stimulus applies every input just after a falling edge, so each value stays steady across the rising edge that samples it. The configuration inputs change only while reset is held or between directed phases. The bench model accounts for a window length change in the middle of a window.

// File: rtl/veto_sync_master.sv
module veto_sync_master #(
  parameter int N_SLV = 16,
  parameter int CW    = 16,
  parameter int WIN_W = 16,
  parameter int GAP_W = 8,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_in,
  output logic [N_SLV-1:0] trig_out,
  input  logic [N_SLV-1:0] slv_busy,
  input  logic [N_SLV-1:0] slot_en,
  output logic             veto,
  input  logic             sync_cmd,
  input  logic [GAP_W-1:0] sync_gap,
  output logic [N_SLV-1:0] sync_out,
  input  logic [WIN_W-1:0] win_len,
  output logic             rec_stb,
  output logic [AW-1:0]    log_ptr,
  input  logic [AW-1:0]    rd_addr,
  output logic [3*CW-1:0]  rd_data,
  output logic [CW-1:0]    vetoed_cnt
);
  localparam int DEPTH = 1 << AW;

  logic             trig_q, veto_q, sync_q, sync_done;
  logic [GAP_W-1:0] since;
  logic [WIN_W-1:0] wcnt;
  logic [CW-1:0]    acc_t, acc_h, acc_r;
  logic [3*CW-1:0]  mem [DEPTH];

  assign veto     = |(slv_busy & slot_en);
  assign trig_out = {N_SLV{trig_in}};
  assign sync_out = {N_SLV{sync_q}};

  wire trig_edge = trig_in & ~trig_q;
  wire veto_edge = veto & ~veto_q;
  wire sync_ok   = !sync_done || (since >= sync_gap);
  wire issue     = sync_cmd & sync_ok & ~sync_q;
  wire win_end   = ({1'b0, wcnt} + 1'b1) >= {1'b0, win_len};

  wire [CW-1:0] nxt_t = acc_t + CW'(trig_edge);
  wire [CW-1:0] nxt_h = acc_h + CW'(veto);
  wire [CW-1:0] nxt_r = acc_r + CW'(veto_edge);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q     <= 1'b0;
      veto_q     <= 1'b0;
      sync_q     <= 1'b0;
      sync_done  <= 1'b0;
      since      <= '0;
      vetoed_cnt <= '0;
    end else begin
      trig_q <= trig_in;
      veto_q <= veto;
      sync_q <= issue;
      if (issue) begin
        sync_done <= 1'b1;
        since     <= '0;
      end else if (trig_edge && since != '1) begin
        since <= since + 1'b1;
      end
      if (trig_edge && veto) vetoed_cnt <= vetoed_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt    <= '0;
      acc_t   <= '0;
      acc_h   <= '0;
      acc_r   <= '0;
      rec_stb <= 1'b0;
      log_ptr <= '0;
    end else if (win_end) begin
      wcnt    <= '0;
      acc_t   <= '0;
      acc_h   <= '0;
      acc_r   <= '0;
      rec_stb <= 1'b1;
      log_ptr <= log_ptr + 1'b1;
    end else begin
      wcnt    <= wcnt + 1'b1;
      acc_t   <= nxt_t;
      acc_h   <= nxt_h;
      acc_r   <= nxt_r;
      rec_stb <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && win_end) mem[log_ptr] <= {nxt_t, nxt_h, nxt_r};
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/veto_sync_master_chk.sv
module veto_sync_master_chk #(
  parameter int N_SLV = 16,
  parameter int CW    = 16,
  parameter int AW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_in,
  input logic [N_SLV-1:0] slv_busy,
  input logic [N_SLV-1:0] slot_en,
  input logic             veto,
  input logic             sync_cmd,
  input logic [N_SLV-1:0] sync_out,
  input logic             rec_stb,
  input logic [AW-1:0]    log_ptr,
  input logic [CW-1:0]    vetoed_cnt
);
  p_veto_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    veto |-> ((slv_busy & slot_en) != '0));

  p_sync_from_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out[0] |-> $past(sync_cmd));

  p_vetoed_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vetoed_cnt != $past(vetoed_cnt)) |-> $past(veto && trig_in));

  p_ptr_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (log_ptr != $past(log_ptr)) |-> rec_stb);

  p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rec_stb |-> (log_ptr == AW'($past(log_ptr) + 1'b1)));
endmodule

bind veto_sync_master veto_sync_master_chk #(.N_SLV(N_SLV), .CW(CW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .slv_busy(slv_busy),
  .slot_en(slot_en), .veto(veto), .sync_cmd(sync_cmd), .sync_out(sync_out),
  .rec_stb(rec_stb), .log_ptr(log_ptr), .vetoed_cnt(vetoed_cnt)
);

// File: tb/veto_sync_master_tb_top.sv
module veto_sync_master_tb_top;
  localparam int PERIOD = 10;
  localparam int N = 16, CW = 16, WIN_W = 16, GAP_W = 8, AW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic trig_in = 1'b0, sync_cmd = 1'b0, veto, rec_stb;
  logic [N-1:0] trig_out, slv_busy = '0, slot_en = '0, sync_out;
  logic [GAP_W-1:0] sync_gap = 8'd3;
  logic [WIN_W-1:0] win_len = 16'd5;
  logic [AW-1:0] log_ptr, rd_addr = '0;
  logic [3*CW-1:0] rd_data;
  logic [CW-1:0] vetoed_cnt;

  always #(PERIOD/2) clk = ~clk;

  veto_sync_master #(.N_SLV(N), .CW(CW), .WIN_W(WIN_W), .GAP_W(GAP_W), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_out(trig_out),
    .slv_busy(slv_busy), .slot_en(slot_en), .veto(veto), .sync_cmd(sync_cmd),
    .sync_gap(sync_gap), .sync_out(sync_out), .win_len(win_len), .rec_stb(rec_stb),
    .log_ptr(log_ptr), .rd_addr(rd_addr), .rd_data(rd_data), .vetoed_cnt(vetoed_cnt)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // {busy, enable, trig, expected veto}
  localparam logic [33:0] VEC [6] = '{
    {16'h0000, 16'hFFFF, 1'b0, 1'b0},
    {16'h0001, 16'hFFFF, 1'b1, 1'b1},
    {16'h8000, 16'h7FFF, 1'b0, 1'b0},
    {16'h8000, 16'h8000, 1'b1, 1'b1},
    {16'hF0F0, 16'h0F0F, 1'b1, 1'b0},
    {16'h0100, 16'h0300, 1'b0, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic m_pt = 0, m_pv = 0, m_sq = 0, m_sdone = 0;
  int m_since = 0, m_w = 0;
  logic [CW-1:0] m_t = 0, m_h = 0, m_r = 0, m_vet = 0;
  logic [AW-1:0] m_ptr = 0;

  task automatic step(input logic t, input logic [N-1:0] b, input logic c);
    logic v, e, es, endw;
    logic [AW-1:0] wp;
    logic [3*CW-1:0] rec;
    trig_in = t; slv_busy = b; sync_cmd = c;
    @(posedge clk);
    v = |(b & slot_en);
    e = t && !m_pt;
    es = c && (!m_sdone || m_since >= sync_gap) && !m_sq;
    if (es) begin m_sdone = 1; m_since = 0; end
    else if (e) m_since++;
    m_sq = es;
    if (e && v) m_vet++;
    m_t += CW'(e); m_h += CW'(v); m_r += CW'(v && !m_pv);
    m_w++;
    endw = (m_w >= win_len);
    wp = m_ptr;
    rec = {m_t, m_h, m_r};
    if (endw) begin m_ptr++; m_t = 0; m_h = 0; m_r = 0; m_w = 0; end
    m_pt = t; m_pv = v;
    @(negedge clk);
    chk(sync_out == (es ? {N{1'b1}} : '0), "R4/R5 sync_out", sync_out, es);
    chk(rec_stb == endw, "R7 rec_stb", rec_stb, endw);
    chk(vetoed_cnt == m_vet, "R6 vetoed_cnt", vetoed_cnt, m_vet);
    if (endw) begin
      rd_addr = wp;
      #1;
      chk(rd_data == rec, "R8/R9 record", rd_data, rec);
      chk(log_ptr == m_ptr, "R7 log_ptr", log_ptr, m_ptr);
    end
  endtask

  initial begin
    #(PERIOD*20000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) begin
      slv_busy = VEC[i][33:18]; slot_en = VEC[i][17:2]; trig_in = VEC[i][1];
      #1;
      chk(veto == VEC[i][0], "R2 veto mask", veto, VEC[i][0]);
      chk(trig_out == {N{VEC[i][1]}}, "R3 trig_out", trig_out, {N{VEC[i][1]}});
    end
    trig_in = 0; slv_busy = '0; slot_en = 16'h00FF;
    repeat (3) @(negedge clk);
    chk(sync_out == '0 && rec_stb == 0, "R1 reset outputs", {sync_out, rec_stb}, 0);
    chk(log_ptr == 0 && vetoed_cnt == 0, "R1 reset counters", {log_ptr, vetoed_cnt}, 0);
    rst_n = 1;

    // R5 first request accepted, then back-to-back and premature ones ignored
    step(0, '0, 1);
    step(0, '0, 1);
    step(0, '0, 1);
    step(1, 16'h0001, 0);
    step(0, 16'h0001, 0);
    step(1, 16'h0100, 0);
    step(0, '0, 1);
    step(1, 16'h0002, 0);
    step(0, '0, 0);
    step(0, '0, 1);
    // R6 under veto and with masked busy
    for (int i = 0; i < 60; i++)
      step(i % 3 == 0, (i % 7 < 3) ? 16'h0004 : ((i % 5 == 0) ? 16'h0200 : '0), i == 40 || i == 41);
    // R7 zero-length window, memory wrap (R9)
    win_len = 0;
    for (int i = 0; i < 20; i++) step(i % 2 == 0, (i % 4 == 1) ? 16'h0080 : '0, 0);
    win_len = 3;
    for (int i = 0; i < 12; i++) step(i % 4 == 0, 16'h0010, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule